// File: doc/BRIEF.md
# Pad Pull-Resistor Programming Sequencer

This block keeps a 2-bit pull setting for each of 54 pads and drives it straight to the pad ring. Software never writes a pad's setting directly. It first writes a shared pull code into a single control register. After a setup delay it raises strobe bits in two per-bank strobe registers. A strobe bit going from 0 to 1 copies the shared code into the matching pad. Software then writes the strobe register back to zero. The settings cannot be read back.

The block enforces the setup delay. A strobe rise that comes too soon after the last control write is refused. A strobe rise made while the shared code is the reserved value is also refused. In both cases every pad keeps its setting and a sticky error flag is raised. Only reset clears that flag.

Top module: `pull_sequencer`

## Requirements
- R1: On reset every pad setting returns to DEFAULT_PULL (off, code 0, by default), the shared code is cleared to off, and setup_err reads 0.
- R2: The shared code is written at byte address 0x94 and only wr_data[1:0] is kept. The encodings are 0 = off, 1 = pull-down, 2 = pull-up, and 3 is reserved. Pad i is reported on pull_state[2i+1:2i].
- R3: Strobe register b sits at address 0x98 + 4b. Bit p of it selects pad 32b + p. Each bit written as 1 while it previously held 0 loads the shared code into its pad. All such bits in one write load together.
- R4: Call the first cycle after the control write N = 1, so a strobe write on that very next cycle has N = 1. A strobe rise on cycle N is accepted only if N > SETUP_CYCLES (default 150). The wait does not restart while no control write occurs, so a later rise is accepted.
- R5: A strobe rise while the shared code is 3 loads nothing.
- R6: A refused strobe rise (R4 or R5) leaves every pad unchanged and sets setup_err. setup_err then stays 1 until reset.
- R7: Writing 1 to a strobe bit that already holds 1 loads nothing. A new shared code therefore never reaches pads whose strobe is held high.
- R8: A control write alone changes no pad. Strobe bits beyond pad 53 and writes to any other address have no effect on any pad.
- R9: No pad ever shows the reserved code 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Byte address of the write |
| wr_data | input | 32 | Write data |
| pull_state | output | 108 | Pad pull settings, 2 bits per pad |
| setup_err | output | 1 | Sticky flag for refused strobe rises |

## Verification
The main function is driven from a table of code, bank and mask triples. These include single pads, the pads at both ends of a bank, pads in both banks, several pads in one write, and codes that overwrite earlier settings. A wrong bank decode, bit-to-pad mapping or code encoding therefore shows up as a mismatch on a specific pad. Directed cases place the strobe at N = SETUP_CYCLES and at N = SETUP_CYCLES + 1 to pin down the setup boundary in both directions. They also hold a strobe high across a code change, write to unused bits and foreign addresses, and strobe with the reserved code. These cases separate the rise detection and the refusal paths from an ordinary load.

// File: rtl/pullseq_pkg.sv
package pullseq_pkg;

  typedef enum logic [1:0] {
    PULL_OFF  = 2'd0,
    PULL_DOWN = 2'd1,
    PULL_UP   = 2'd2,
    PULL_RSVD = 2'd3
  } pull_code_e;

  // Byte address of strobe bank b.
  function automatic int unsigned strobe_addr(int unsigned base, int unsigned b);
    return base + 4 * b;
  endfunction

  // Number of pads served by bank b.
  function automatic int unsigned pads_in_bank(int unsigned total, int unsigned bw,
                                               int unsigned b);
    int unsigned rem;
    rem = total - b * bw;
    return (rem > bw) ? bw : rem;
  endfunction

  // Only non-reserved codes may be loaded into a pad.
  function automatic logic code_loadable(logic [1:0] c);
    return c != PULL_RSVD;
  endfunction

endpackage

// File: rtl/pullseq_setup_timer.sv
module pullseq_setup_timer #(
  parameter int unsigned SETUP_CYCLES = 150
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic ready
);
  localparam int unsigned CW = $clog2(SETUP_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(SETUP_CYCLES);

  logic [CW-1:0] wait_q;

  // Saturating count of cycles since the last control write.
  always_ff @(posedge clk) begin
    if (!rst_n)              wait_q <= LIMIT;
    else if (restart)        wait_q <= '0;
    else if (wait_q != LIMIT) wait_q <= wait_q + 1'b1;
  end

  assign ready = (wait_q == LIMIT);
endmodule

// File: rtl/pullseq_strobe_bank.sv
module pullseq_strobe_bank #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic [WIDTH-1:0] bits,
  output logic [WIDTH-1:0] rise
);
  logic [WIDTH-1:0] level_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   level_q <= '0;
    else if (hit) level_q <= bits;
  end

  // A 0->1 transition of a stored strobe bit.
  assign rise = hit ? (bits & ~level_q) : '0;
endmodule

// File: rtl/pullseq_pad_store.sv
module pullseq_pad_store #(
  parameter int unsigned NUM_PINS     = 54,
  parameter logic [1:0]  DEFAULT_PULL = 2'd0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PINS-1:0]   load,
  input  logic [1:0]            code,
  output logic [2*NUM_PINS-1:0] state
);
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pad
    logic [1:0] pad_q;
    always_ff @(posedge clk) begin
      if (!rst_n)       pad_q <= DEFAULT_PULL;
      else if (load[i]) pad_q <= code;
    end
    assign state[2*i +: 2] = pad_q;
  end
endmodule

// File: rtl/pull_sequencer.sv
module pull_sequencer #(
  parameter int unsigned NUM_PINS     = 54,
  parameter int unsigned SETUP_CYCLES = 150,
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned BANK_W       = 32,
  parameter int unsigned CTRL_OFS     = 32'h94,
  parameter int unsigned STROBE_BASE  = 32'h98,
  parameter logic [1:0]  DEFAULT_PULL = 2'd0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [BANK_W-1:0]     wr_data,
  output logic [2*NUM_PINS-1:0] pull_state,
  output logic                  setup_err
);
  import pullseq_pkg::*;

  localparam int unsigned NUM_BANKS = (NUM_PINS + BANK_W - 1) / BANK_W;

  // Named internal events.
  logic                ctrl_wr;
  logic [1:0]          code_q;
  logic                setup_ok;
  logic [NUM_PINS-1:0] rise_vec;
  logic                capture_en;
  logic [NUM_PINS-1:0] load_vec;
  logic                reject;

  assign ctrl_wr = wr_en && (wr_addr == ADDR_W'(CTRL_OFS));

  always_ff @(posedge clk) begin
    if (!rst_n)       code_q <= PULL_OFF;
    else if (ctrl_wr) code_q <= wr_data[1:0];
  end

  pullseq_setup_timer #(.SETUP_CYCLES(SETUP_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (ctrl_wr),
    .ready   (setup_ok)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int unsigned PB = pads_in_bank(NUM_PINS, BANK_W, b);
    logic          hit;
    logic [PB-1:0] bank_rise;
    assign hit = wr_en && (wr_addr == ADDR_W'(strobe_addr(STROBE_BASE, b)));
    pullseq_strobe_bank #(.WIDTH(PB)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .hit   (hit),
      .bits  (wr_data[PB-1:0]),
      .rise  (bank_rise)
    );
    assign rise_vec[b*BANK_W +: PB] = bank_rise;
  end

  assign capture_en = setup_ok && code_loadable(code_q);
  assign load_vec   = rise_vec & {NUM_PINS{capture_en}};
  assign reject     = (|rise_vec) && !capture_en;

  always_ff @(posedge clk) begin
    if (!rst_n)      setup_err <= 1'b0;
    else if (reject) setup_err <= 1'b1;
  end

  pullseq_pad_store #(.NUM_PINS(NUM_PINS), .DEFAULT_PULL(DEFAULT_PULL)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load_vec),
    .code  (code_q),
    .state (pull_state)
  );
endmodule

// File: rtl/pull_sequencer_chk.sv
module pull_sequencer_chk #(
  parameter int unsigned NUM_PINS     = 54,
  parameter int unsigned SETUP_CYCLES = 150,
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned BANK_W       = 32,
  parameter int unsigned CTRL_OFS     = 32'h94
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic [ADDR_W-1:0]     wr_addr,
  input logic [BANK_W-1:0]     wr_data,
  input logic [2*NUM_PINS-1:0] pull_state,
  input logic                  setup_err,
  input logic [NUM_PINS-1:0]   rise_vec
);
  localparam int unsigned CW = $clog2(SETUP_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(SETUP_CYCLES);

  logic          is_ctrl;
  logic [CW-1:0] gap_q;
  logic [1:0]    shadow_code;

  assign is_ctrl = wr_en && (wr_addr == ADDR_W'(CTRL_OFS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_q       <= LIMIT;
      shadow_code <= 2'd0;
    end else begin
      if (is_ctrl)             gap_q <= '0;
      else if (gap_q != LIMIT) gap_q <= gap_q + 1'b1;
      if (is_ctrl) shadow_code <= wr_data[1:0];
    end
  end

  function automatic logic any_reserved(logic [2*NUM_PINS-1:0] s);
    logic r;
    r = 1'b0;
    for (int i = 0; i < NUM_PINS; i++) r = r | (s[2*i +: 2] == 2'd3);
    return r;
  endfunction

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    setup_err |=> setup_err);

  // R6
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(setup_err) |-> $past(wr_en));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(pull_state));

  // R8
  ctrl_nochange_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_ctrl |=> $stable(pull_state));

  // R4
  setup_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_q != LIMIT) |=> $stable(pull_state));

  // R5
  reserved_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shadow_code == 2'd3) |=> $stable(pull_state));

  // R7
  rise_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|rise_vec) |=> $stable(pull_state));

  // R9
  legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_reserved(pull_state));
endmodule

bind pull_sequencer pull_sequencer_chk #(
  .NUM_PINS     (NUM_PINS),
  .SETUP_CYCLES (SETUP_CYCLES),
  .ADDR_W       (ADDR_W),
  .BANK_W       (BANK_W),
  .CTRL_OFS     (CTRL_OFS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .pull_state (pull_state),
  .setup_err  (setup_err),
  .rise_vec   (rise_vec)
);

// File: tb/pull_sequencer_tb.sv
module pull_sequencer_tb;
  localparam int NP    = 54;
  localparam int SETUP = 150;
  localparam logic [7:0] A_CODE = 8'h94;
  localparam logic [7:0] A_STB0 = 8'h98;
  localparam logic [7:0] A_STB1 = 8'h9C;

  // {code[1:0], bank, mask[31:0]}
  localparam int NV = 6;
  localparam logic [34:0] VEC [NV] = '{
    {2'd2, 1'b0, 32'h0000_0001},
    {2'd1, 1'b0, 32'h8000_0010},
    {2'd2, 1'b1, 32'h0020_0001},
    {2'd1, 1'b1, 32'h0000_0100},
    {2'd0, 1'b0, 32'h0000_0011},
    {2'd2, 1'b0, 32'h0F00_0000}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [7:0]    wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic [2*NP-1:0] pull_state;
  logic          setup_err;

  int checks = 0;
  int fails  = 0;
  logic [1:0] mdl [NP];

  always #5 clk = ~clk;

  pull_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pull_state(pull_state), .setup_err(setup_err)
  );

  function automatic logic [2*NP-1:0] packed_model();
    logic [2*NP-1:0] v;
    for (int i = 0; i < NP; i++) v[2*i +: 2] = mdl[i];
    return v;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NP; i++) mdl[i] = 2'd0;
  endtask

  task automatic chk_state(input string req);
    checks++;
    if (pull_state !== packed_model()) begin
      fails++;
      $display("FAIL %s: pull_state act=%h exp=%h", req, pull_state, packed_model());
    end
  endtask

  task automatic chk_val(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // Model update from R3/R5: loads code into every real pad of the mask.
  task automatic model_load(input logic [1:0] code, input int bank, input logic [31:0] mask);
    if (code != 2'd3)
      for (int p = 0; p < 32; p++)
        if (mask[p] && (32*bank + p) < NP) mdl[32*bank + p] = code;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog: run did not complete");
    summary();
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk_state("R1 reset pads");
    chk_val("R1 reset err", {7'd0, setup_err}, 8'd0);

    // R2 R3 table walk: code, full setup wait, strobe, release
    for (int v = 0; v < NV; v++) begin
      logic [1:0]  c;
      logic        bk;
      logic [31:0] m;
      c = VEC[v][34:33]; bk = VEC[v][32]; m = VEC[v][31:0];
      wr(A_CODE, {30'h3FFF_FFFF, c});  // upper bits ignored (R2)
      repeat (SETUP) @(negedge clk);
      wr(bk ? A_STB1 : A_STB0, m);
      model_load(c, int'(bk), m);
      wr(bk ? A_STB1 : A_STB0, 32'h0);
      chk_state("R2 R3 table vector");
    end
    chk_val("R6 no error in table", {7'd0, setup_err}, 8'd0);

    // R4 early strobe at N = SETUP is refused
    wr(A_CODE, 32'd1);
    repeat (SETUP - 1) @(negedge clk);
    wr(A_STB0, 32'h0000_0400);
    chk_state("R4 early strobe refused");
    chk_val("R6 error after early strobe", {7'd0, setup_err}, 8'd1);
    wr(A_STB0, 32'h0);
    // R4 wait continues without a new control write
    wr(A_STB0, 32'h0000_0400);
    model_load(2'd1, 0, 32'h0000_0400);
    wr(A_STB0, 32'h0);
    chk_state("R4 later strobe accepted");
    chk_val("R6 error sticky", {7'd0, setup_err}, 8'd1);

    do_reset();
    chk_state("R1 second reset pads");
    chk_val("R1 second reset err", {7'd0, setup_err}, 8'd0);

    // R4 exact boundary N = SETUP+1 accepted
    wr(A_CODE, 32'd2);
    repeat (SETUP) @(negedge clk);
    wr(A_STB0, 32'h0000_0800);
    model_load(2'd2, 0, 32'h0000_0800);
    chk_state("R4 boundary accepted");
    chk_val("R4 boundary no error", {7'd0, setup_err}, 8'd0);
    wr(A_STB0, 32'h0);

    // R7 strobe held high across a code change
    wr(A_CODE, 32'd2);
    repeat (SETUP) @(negedge clk);
    wr(A_STB0, 32'h0000_0020);
    wr(A_CODE, 32'd1);
    repeat (SETUP) @(negedge clk);
    wr(A_STB0, 32'h0000_0060);
    chk_val("R7 held pad keeps code", {6'd0, pull_state[11:10]}, 8'd2);
    chk_val("R7 newly risen pad loads", {6'd0, pull_state[13:12]}, 8'd1);
    mdl[5] = 2'd2; mdl[6] = 2'd1;
    wr(A_STB0, 32'h0);

    // R8 unused bits, foreign address, bare control write
    wr(A_STB1, 32'hFFC0_0000);
    wr(8'h20, 32'hFFFF_FFFF);
    chk_state("R8 unused bits and foreign address");
    wr(A_STB1, 32'h0);
    wr(A_CODE, 32'd2);
    chk_state("R8 control write alone");
    chk_val("R8 no error", {7'd0, setup_err}, 8'd0);

    // R5 reserved code refused
    wr(A_CODE, 32'd3);
    repeat (SETUP) @(negedge clk);
    wr(A_STB0, 32'h0000_0080);
    chk_state("R5 reserved code loads nothing");
    chk_val("R5 R6 reserved code error", {7'd0, setup_err}, 8'd1);
    wr(A_STB0, 32'h0);

    summary();
    $finish;
  end
endmodule